// File: doc/BRIEF.md
# SRAM-Backed FIFO Controller

This controller turns an external single-port static RAM into a first-in first-out buffer. A writer and a reader each see a ready/request pair. The controller itself never touches the data. It sequences the shared address bus and the two active-low memory strobes (write strobe and output enable) so that the writer's words land in consecutive locations and come back out to the reader in the same order.

Every memory access is a short, fixed sequence of clock cycles. A write takes three clocks and a read takes three clocks. When both sides ask at once, the controller runs a single five-clock combined cycle: it reads first, then writes. An up/down occupancy count, one bit wider than the address, produces the empty, half-full and full flags. These flags gate which accesses may start.

The state machine has nine states:

- `ST_IDLE` is the only state that samples requests.
- The write path is `ST_WR_ARM` (address presented) then `ST_WR_DONE` (strobe low).
- The read path is `ST_RD_HOLD` then `ST_RD_DONE`, with output enable low in both.
- The combined path is `ST_CB_RD`, `ST_CB_SWAP`, `ST_CB_WR` and `ST_CB_DONE`.

The transitions are:

- `ST_IDLE` goes to `ST_WR_ARM` on a write launch, to `ST_RD_HOLD` on a read launch, and to `ST_CB_RD` on a combined launch.
- Every other state moves to the next state in its own path.
- `ST_WR_DONE`, `ST_RD_DONE` and `ST_CB_DONE` return to `ST_IDLE`.

Top module: `sram_fifo_ctrl`

## Requirements
- R1: Reset is active-high and sampled on the rising edge. On the next clock, addr is 0, both strobes are high, empty is 1, full and half_full are 0, wr_rdy is 1 and rd_rdy is 0. Both pointers and the occupancy count restart at 0.
- R2: wr_rdy is 1 exactly when the controller is in `ST_IDLE` and full is 0.
- R3: A write launches from idle when wr_req=1, full=0, and either rd_req=0 or empty=1. On the next clock, addr holds the write pointer.
- R4: In a write, sram_we_n is low for exactly one clock: the second clock after launch. The controller is back in idle on the third clock. The write pointer and the occupancy count then rise by one.
- R5: A read launches from idle when rd_req=1, wr_req=0 and empty=0. For the two clocks after launch, addr holds the read pointer and sram_oe_n is low. After that, the occupancy count falls by one and the controller returns to idle.
- R6: A combined cycle launches from idle when both requests are 1 and empty=0. It takes five clocks:
  - In clocks 1 and 2, sram_oe_n is low at the read address.
  - In clock 3, both strobes are high and addr holds the write pointer.
  - In clock 4, sram_we_n is low.
  - In clock 5, sram_we_n is high again.
  - The net occupancy is unchanged and both pointers advance by one.
- R7: If both requests are 1 while empty=1, a plain write runs.
- R8: empty means the count is 0, half_full means the count is at least DEPTH/2, and full means the count equals DEPTH.
- R9: rd_rdy is 1 exactly when the controller is idle and empty is 0. No write launches while full, and no read launches while empty.
- R10: Both pointers wrap modulo DEPTH, and words are read back in the order they were written.
- R11: Request levels seen outside `ST_IDLE` have no effect.
- R12: sram_we_n and sram_oe_n are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Writer asks to store one word |
| rd_req | input | 1 | Reader asks to fetch one word |
| wr_rdy | output | 1 | Controller can accept a write |
| rd_rdy | output | 1 | Controller can serve a read |
| sram_addr | output | ADDR_W | Registered memory address |
| sram_we_n | output | 1 | Active-low memory write strobe |
| sram_oe_n | output | 1 | Active-low memory output enable |
| empty | output | 1 | No unread words stored |
| half_full | output | 1 | At least half the locations hold unread words |
| full | output | 1 | Every location holds an unread word |

## Verification
A wrong pointer shows up on sram_addr at the very next access of that kind. It also shows up later as a word returned out of order by the behavioural memory. A miscounted occupancy shows up on the flags and the ready outputs in the clock after the access that miscounted. A state machine that strays shows up within one clock as a strobe at the wrong time, or as a ready output raised while busy. The bench's per-clock reference model catches each of these in the cycle it first appears.

// File: rtl/fifo_ctrl_pkg.sv
package fifo_ctrl_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_ARM,
        ST_WR_DONE,
        ST_RD_HOLD,
        ST_RD_DONE,
        ST_CB_RD,
        ST_CB_SWAP,
        ST_CB_WR,
        ST_CB_DONE
    } ctrl_state_e;
endpackage

// File: rtl/ptr_counter.sv
module ptr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (step)
            value <= value + W'(1);
    end
endmodule

// File: rtl/occ_tracker.sv
module occ_tracker #(
    parameter int ADDR_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic up,
    input  logic dn,
    output logic empty,
    output logic half_full,
    output logic full
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] HALF_MARK = CNT_W'(1) << (ADDR_W - 1);

    logic [CNT_W-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (rst)
            occ_q <= '0;
        else if (up && !dn)
            occ_q <= occ_q + CNT_W'(1);
        else if (dn && !up)
            occ_q <= occ_q - CNT_W'(1);
    end

    assign empty     = (occ_q == '0);
    assign full      = occ_q[ADDR_W];
    assign half_full = (occ_q >= HALF_MARK);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !(up && !dn));
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !(dn && !up));
    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));
endmodule

// File: rtl/sram_fifo_ctrl.sv
module sram_fifo_ctrl
    import fifo_ctrl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              rd_req,
    output logic              wr_rdy,
    output logic              rd_rdy,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              empty,
    output logic              half_full,
    output logic              full
);
    ctrl_state_e state_q, state_d;
    logic [ADDR_W-1:0] wptr, rptr;
    logic is_idle, go_wr, go_rd, go_cb;
    logic wr_step, rd_step, occ_up, occ_dn;

    assign is_idle = (state_q == ST_IDLE);
    assign go_cb   = is_idle && wr_req && rd_req && !empty;
    assign go_wr   = is_idle && wr_req && !full && (!rd_req || empty);
    assign go_rd   = is_idle && rd_req && !wr_req && !empty;

    assign rd_step = go_rd || go_cb;
    assign wr_step = (state_q == ST_WR_DONE) || (state_q == ST_CB_DONE);
    assign occ_up  = wr_step;
    assign occ_dn  = (state_q == ST_RD_DONE) || (state_q == ST_CB_SWAP);

    ptr_counter #(.W(ADDR_W)) u_wptr (
        .clk(clk), .rst(rst), .step(wr_step), .value(wptr)
    );
    ptr_counter #(.W(ADDR_W)) u_rptr (
        .clk(clk), .rst(rst), .step(rd_step), .value(rptr)
    );
    occ_tracker #(.ADDR_W(ADDR_W)) u_occ (
        .clk(clk), .rst(rst), .up(occ_up), .dn(occ_dn),
        .empty(empty), .half_full(half_full), .full(full)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_cb)      state_d = ST_CB_RD;
                else if (go_wr) state_d = ST_WR_ARM;
                else if (go_rd) state_d = ST_RD_HOLD;
            end
            ST_WR_ARM:  state_d = ST_WR_DONE;
            ST_WR_DONE: state_d = ST_IDLE;
            ST_RD_HOLD: state_d = ST_RD_DONE;
            ST_RD_DONE: state_d = ST_IDLE;
            ST_CB_RD:   state_d = ST_CB_SWAP;
            ST_CB_SWAP: state_d = ST_CB_WR;
            ST_CB_WR:   state_d = ST_CB_DONE;
            ST_CB_DONE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // registered memory-side outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sram_addr <= '0;
            sram_we_n <= 1'b1;
            sram_oe_n <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go_cb || go_rd) begin
                        sram_addr <= rptr;
                        sram_oe_n <= 1'b0;
                    end else if (go_wr) begin
                        sram_addr <= wptr;
                    end
                end
                ST_WR_ARM:  sram_we_n <= 1'b0;
                ST_WR_DONE: sram_we_n <= 1'b1;
                ST_RD_HOLD: ;
                ST_RD_DONE: sram_oe_n <= 1'b1;
                ST_CB_RD:   ;
                ST_CB_SWAP: begin
                    sram_oe_n <= 1'b1;
                    sram_addr <= wptr;
                end
                ST_CB_WR:   sram_we_n <= 1'b0;
                ST_CB_DONE: sram_we_n <= 1'b1;
                default:    ;
            endcase
        end
    end

    assign wr_rdy = is_idle && !full;
    assign rd_rdy = is_idle && !empty;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (sram_addr == '0) && sram_we_n && sram_oe_n && empty && !full && !half_full);
    // R4
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |=> sram_we_n);
    // R5
    oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_oe_n) |=> !sram_oe_n);
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!sram_we_n && !sram_oe_n));
    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> $stable(sram_addr));
    // R11
    read_from_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_oe_n) |-> $past(rd_rdy));
endmodule

// File: tb/tb_sram_fifo_ctrl.sv
module tb_sram_fifo_ctrl;
    localparam int BW = 4;
    localparam int D  = 1 << BW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_req = 1'b0, rd_req = 1'b0;
    logic wr_rdy, rd_rdy, sram_we_n, sram_oe_n, empty, half_full, full;
    logic [BW-1:0] sram_addr;

    sram_fifo_ctrl #(.ADDR_W(BW)) dut (
        .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req),
        .wr_rdy(wr_rdy), .rd_rdy(rd_rdy), .sram_addr(sram_addr),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .empty(empty), .half_full(half_full), .full(full)
    );

    always #5 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string phase = "R1";

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s phase %s: actual %0d expected %0d at %0t", tag, phase, act, exp, $time);
        end
    endtask

    // reference model (behavioural)
    int m_cnt, m_rp, m_wp, m_ph, m_kind, m_addr;
    bit m_we, m_oe;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_rp = 0; m_wp = 0; m_ph = 0; m_kind = 0;
            m_addr = 0; m_we = 1; m_oe = 1;
        end else if (m_kind == 0) begin
            if (wr_req && rd_req && m_cnt > 0) begin
                m_kind = 3; m_ph = 1; m_addr = m_rp; m_rp = (m_rp + 1) % D; m_oe = 0;
            end else if (wr_req && m_cnt < D && (!rd_req || m_cnt == 0)) begin
                m_kind = 1; m_ph = 1; m_addr = m_wp;
            end else if (rd_req && !wr_req && m_cnt > 0) begin
                m_kind = 2; m_ph = 1; m_addr = m_rp; m_rp = (m_rp + 1) % D; m_oe = 0;
            end
        end else if (m_kind == 1) begin
            if (m_ph == 1) begin m_we = 0; m_ph = 2; end
            else begin m_we = 1; m_wp = (m_wp + 1) % D; m_cnt++; m_kind = 0; end
        end else if (m_kind == 2) begin
            if (m_ph == 1) m_ph = 2;
            else begin m_oe = 1; m_cnt--; m_kind = 0; end
        end else begin
            case (m_ph)
                1: m_ph = 2;
                2: begin m_oe = 1; m_cnt--; m_addr = m_wp; m_ph = 3; end
                3: begin m_we = 0; m_ph = 4; end
                default: begin m_we = 1; m_wp = (m_wp + 1) % D; m_cnt++; m_kind = 0; end
            endcase
        end
    end

    // behavioural SRAM and data-order tracking
    logic [15:0] mem [D];
    logic [15:0] wdata = 16'h100;
    logic [15:0] expq[$];
    bit prev_oe = 1;

    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            expq.delete();
            prev_oe = 1;
        end else begin
            chk(sram_addr == BW'(m_addr), "R3", int'(sram_addr), m_addr);
            chk(sram_we_n == m_we, "R4", int'(sram_we_n), int'(m_we));
            chk(sram_oe_n == m_oe, "R5", int'(sram_oe_n), int'(m_oe));
            chk(empty == (m_cnt == 0), "R8", int'(empty), int'(m_cnt == 0));
            chk(half_full == (m_cnt >= D/2), "R8", int'(half_full), int'(m_cnt >= D/2));
            chk(full == (m_cnt == D), "R8", int'(full), int'(m_cnt == D));
            chk(wr_rdy == (m_kind == 0 && m_cnt < D), "R2", int'(wr_rdy), int'(m_kind == 0 && m_cnt < D));
            chk(rd_rdy == (m_kind == 0 && m_cnt > 0), "R9", int'(rd_rdy), int'(m_kind == 0 && m_cnt > 0));
            chk(!(!sram_we_n && !sram_oe_n), "R12", int'({sram_we_n, sram_oe_n}), 1);
            if (!sram_we_n) begin
                mem[sram_addr] = wdata;
                expq.push_back(wdata);
                wdata = wdata + 16'd1;
            end
            if (!sram_oe_n && prev_oe) begin
                if (expq.size() == 0) chk(0, "R10", 0, 1);
                else begin
                    logic [15:0] e;
                    e = expq.pop_front();
                    chk(mem[sram_addr] == e, "R10", int'(mem[sram_addr]), int'(e));
                end
            end
            prev_oe = sram_oe_n;
        end
    end

    task automatic run(input bit w, input bit r, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_req = w; rd_req = r;
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state observed right after reset
        chk(sram_addr == 0, "R1", int'(sram_addr), 0);
        chk(sram_we_n && sram_oe_n, "R1", int'({sram_we_n, sram_oe_n}), 3);
        chk(empty && !full && !half_full, "R1", int'({empty, full, half_full}), 4);
        chk(wr_rdy && !rd_rdy, "R1", int'({wr_rdy, rd_rdy}), 2);

        phase = "R3"; run(1, 0, 70);               // fill until full, extra requests blocked
        chk(full == 1, "R9", int'(full), 1);
        phase = "R6"; run(1, 1, 40);               // combined cycles while full
        @(negedge clk);
        chk(full == 1, "R6", int'(full), 1);
        phase = "R5"; run(0, 1, 70);               // drain until empty
        chk(empty == 1, "R9", int'(empty), 1);
        phase = "R7"; run(1, 1, 1);                // both high while empty: plain write
        run(1, 1, 20);
        phase = "R11";                             // toggling requests during busy cycles
        for (int i = 0; i < 200; i++) run(i[0], i[1], 1);
        phase = "R10";                             // pseudo-random mix, pointer wrap
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run(lfsr[0] | lfsr[3], lfsr[5] | lfsr[7], 1);
        end
        phase = "R1"; run(1, 0, 4);                // reset mid-operation
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; wr_req = 0; rd_req = 0;
        chk(sram_addr == 0 && empty && sram_we_n && sram_oe_n, "R1",
            int'({sram_addr, empty, sram_we_n, sram_oe_n}), 7);
        phase = "R2"; run(0, 0, 10);
        summary();
    end

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog phase %s: actual %0d expected %0d", phase, cycles, 0);
        summary();
    end
endmodule